// File: doc/BRIEF.md
# Per-Device Bus Wait-State Ready Generator

This block produces the processor's active-low ready signal for each bus cycle. When the address strobe is sampled low, the block reads the one-hot device select that the address decoder drives. It then holds ready off for a wait count. Each device has its own wait count, and each count is a parameter, so the counts can be raised when the bus clock is raised. Once the count has run out, ready is driven low for exactly one clock and the block goes back to idle.

One device has no wait count. It is a peripheral with its own data-acknowledge handshake. For a cycle to that device, the acknowledge is passed through a two-flop synchronizer, and the synchronized acknowledge ends the cycle. If a strobe arrives while no device is selected, a default timeout count is used, so an unmapped access cannot hang the bus.

Top module: `wait_rdy_gen`

## Requirements
- R1: While rst_ni is low, and afterwards until the first address strobe, rdy_no stays high (deasserted).
- R2: A cycle to a counted device i is started by a rising clock edge that samples ads_ni low while the block is idle. For such a cycle, rdy_no goes low after the (DEV_WAIT[i]+1)-th rising edge that follows the starting edge. Defaults: device bit 1 waits 2 clocks and device bit 2 waits 5 clocks.
- R3: A device whose count is zero (default: device bit 0) gets rdy_no low after the first rising edge that follows the starting edge.
- R4: rdy_no is low for exactly one clock per cycle. It then stays high until a new strobe starts a new cycle.
- R5: If the strobe arrives while no bit of dev_sel_i is set, the cycle uses TIMEOUT (default 12) as its count.
- R6: A cycle to the acknowledge device (default: select bit 3) uses no counter. Suppose rising edge A is the first edge that samples dtack_ni low. Then rdy_no goes low after edge A+2, which is the delay of the two-flop synchronizer.
- R7: During an acknowledge-device cycle, rdy_no stays high for as long as dtack_ni stays high, however long that is.
- R8: A strobe that arrives while a cycle is still pending is ignored. It neither shortens nor restarts the pending cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_ni | input | 1 | Address strobe, active low |
| dev_sel_i | input | NUM_DEV | One-hot device select from the address decoder |
| dtack_ni | input | 1 | Asynchronous data acknowledge from the handshake device, active low |
| rdy_no | output | 1 | Processor ready, active low |

## Verification
The bench measures the exact edge at which ready falls for a zero-wait device, for two counted devices and for the unmapped timeout. An off-by-one in the counter load or in the terminal test would show up as a cycle that is one clock short or one clock long. A second strobe is injected into a pending slow cycle. A block that reloads the counter on that strobe would end the cycle early, after the wrong device's count. The acknowledge path is first held off for many clocks, to catch a design that still counts for that device. It is then released, to catch a synchronizer with too few or too many stages. Every ready pulse is also checked to last exactly one clock.

// File: rtl/wait_rdy_pkg.sv
package wait_rdy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } wst_e;
endpackage

// File: rtl/wait_ack_sync.sv
module wait_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_ni,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], ~d_ni};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/wait_cnt_pick.sv
module wait_cnt_pick #(
  parameter int NUM_DEV = 4,
  parameter int CNT_W   = 8,
  parameter logic [NUM_DEV-1:0][CNT_W-1:0] DEV_WAIT = '0,
  parameter logic [CNT_W-1:0] TIMEOUT = '1
) (
  input  logic [NUM_DEV-1:0] sel_i,
  output logic [CNT_W-1:0]   cnt_o
);
  // lowest set select bit wins; none selected falls back to timeout
  always_comb begin
    cnt_o = TIMEOUT;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (sel_i[i]) cnt_o = DEV_WAIT[i];
    end
  end
endmodule

// File: rtl/wait_ctrl.sv
module wait_ctrl
  import wait_rdy_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ack_dev_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             ack_i,
  output logic             rdy_o
);
  wst_e             st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (ack_dev_i) st_q <= ST_ACK;
          else begin
            st_q  <= ST_WAIT;
            cnt_q <= load_i;
          end
        end
        ST_WAIT: if (cnt_q == '0) begin
          rdy_q <= 1'b1;
          st_q  <= ST_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_ACK: if (ack_i) begin
          rdy_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rdy_o = rdy_q;

  // R4
  rdy_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q |=> !rdy_q);
  // R2
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i && !ack_dev_i) |=> (st_q == ST_WAIT && cnt_q == $past(load_i)));
  // R8
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && cnt_q != '0) |=> (st_q == ST_WAIT && cnt_q == $past(cnt_q) - 1'b1 && !rdy_q));
  // R6
  ack_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACK && ack_i) |=> rdy_q);
  // R7
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACK && !ack_i) |=> (!rdy_q && st_q == ST_ACK));
endmodule

// File: rtl/wait_rdy_gen.sv
module wait_rdy_gen #(
  parameter int NUM_DEV = 4,
  parameter int CNT_W   = 8,
  parameter logic [NUM_DEV-1:0][CNT_W-1:0] DEV_WAIT = {8'd0, 8'd5, 8'd2, 8'd0},
  parameter int ACK_DEV = 3,
  parameter logic [CNT_W-1:0] TIMEOUT = 8'd12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ads_ni,
  input  logic [NUM_DEV-1:0] dev_sel_i,
  input  logic               dtack_ni,
  output logic               rdy_no
);
  logic [CNT_W-1:0] load;
  logic             ack_s;
  logic             rdy;

  wait_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_ni  (dtack_ni),
    .q_o   (ack_s)
  );

  wait_cnt_pick #(
    .NUM_DEV (NUM_DEV),
    .CNT_W   (CNT_W),
    .DEV_WAIT(DEV_WAIT),
    .TIMEOUT (TIMEOUT)
  ) u_pick (
    .sel_i(dev_sel_i),
    .cnt_o(load)
  );

  wait_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (!ads_ni),
    .ack_dev_i(dev_sel_i[ACK_DEV]),
    .load_i   (load),
    .ack_i    (ack_s),
    .rdy_o    (rdy)
  );

  assign rdy_no = ~rdy;

  // R1
  rst_rdy_chk: assert property (@(posedge clk_i) !rst_ni |-> rdy_no);
endmodule

// File: tb/wait_rdy_gen_test.sv
`timescale 1ns/1ps
module wait_rdy_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ads_ni = 1'b1;
  logic [3:0] dev_sel_i = '0;
  logic       dtack_ni = 1'b1;
  logic       rdy_no;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wait_rdy_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ads_ni(ads_ni),
    .dev_sel_i(dev_sel_i), .dtack_ni(dtack_ni), .rdy_no(rdy_no)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // start a cycle, return edges from start edge until rdy low, then check pulse width
  task automatic run_cycle(input logic [3:0] sel, input int exp_lat, input string req);
    int k;
    @(negedge clk_i);
    ads_ni = 1'b0; dev_sel_i = sel;
    @(negedge clk_i);
    ads_ni = 1'b1; dev_sel_i = '0;
    k = 0;
    while (rdy_no && k < 40) begin
      @(negedge clk_i);
      k++;
    end
    chk(k == exp_lat, req, k, exp_lat);
    @(negedge clk_i);
    chk(rdy_no == 1'b1, "R4 pulse width", rdy_no, 1);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(rdy_no == 1'b1, "R1 in reset", rdy_no, 1);
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(rdy_no == 1'b1, "R1 idle after reset", rdy_no, 1);
    end
  endtask

  task automatic t_counted;
    run_cycle(4'b0001, 1, "R3 zero wait");
    run_cycle(4'b0010, 3, "R2 dev1 wait 2");
    run_cycle(4'b0100, 6, "R2 dev2 wait 5");
    run_cycle(4'b0000, 13, "R5 timeout");
  endtask

  task automatic t_idle_after;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      chk(rdy_no == 1'b1, "R4 no ready without strobe", rdy_no, 1);
    end
  endtask

  task automatic t_ignore;
    int k;
    @(negedge clk_i);
    ads_ni = 1'b0; dev_sel_i = 4'b0100;
    @(negedge clk_i);
    ads_ni = 1'b1; dev_sel_i = '0;
    @(negedge clk_i);
    ads_ni = 1'b0; dev_sel_i = 4'b0001;
    k = 1;
    @(negedge clk_i);
    ads_ni = 1'b1; dev_sel_i = '0;
    k++;
    chk(rdy_no == 1'b1, "R8 second strobe ignored", rdy_no, 1);
    while (rdy_no && k < 40) begin
      @(negedge clk_i);
      k++;
    end
    chk(k == 6, "R8 pending cycle length", k, 6);
    @(negedge clk_i);
    chk(rdy_no == 1'b1, "R4 pulse width", rdy_no, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(rdy_no == 1'b1, "R8 no restarted cycle", rdy_no, 1);
    end
  endtask

  task automatic t_ack;
    int k;
    @(negedge clk_i);
    ads_ni = 1'b0; dev_sel_i = 4'b1000;
    @(negedge clk_i);
    ads_ni = 1'b1; dev_sel_i = '0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      chk(rdy_no == 1'b1, "R7 held while no ack", rdy_no, 1);
    end
    dtack_ni = 1'b0;
    k = 0;
    while (rdy_no && k < 10) begin
      @(negedge clk_i);
      k++;
    end
    chk(k == 3, "R6 sync latency", k, 3);
    @(negedge clk_i);
    dtack_ni = 1'b1;
    chk(rdy_no == 1'b1, "R4 ack pulse width", rdy_no, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(rdy_no == 1'b1, "R4 idle after ack", rdy_no, 1);
    end
  endtask

  task automatic t_reset_mid;
    @(negedge clk_i);
    ads_ni = 1'b0; dev_sel_i = 4'b0100;
    @(negedge clk_i);
    ads_ni = 1'b1; dev_sel_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      chk(rdy_no == 1'b1, "R1 reset clears pending", rdy_no, 1);
    end
  endtask

  initial begin
    t_reset();
    t_counted();
    t_idle_after();
    t_ignore();
    t_ack();
    t_reset_mid();
    run_cycle(4'b0010, 3, "R2 after reset");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule